// File: doc/BRIEF.md
# Glitch-Free Output Clock Group Stop Controller

This block sits between a divided source clock and one group of output clock pins (a processor, bus or memory group). An asynchronous active-low stop request halts the group. The block brings the request into the group clock domain through a synchronizer chain. A small run/halt controller decides when the group may stop or restart. A bank of enable registers clocked on the falling edge then gates each output. All gating changes happen while the source clock is low, so a stopped output rests at 0 and a restarted output always begins with a complete high phase.

Each output has its own enable bit. A cleared bit holds that output low whatever the group state. Outputs named in a parameter mask run freely and ignore the stop request. One more output can be kept running during a stop by setting a control bit. After each restart the group delivers a minimum number of pulses before a new stop may take effect.

A mode input chooses how the shared pin is used. In mobile mode the pin carries the stop request. In desktop mode the request is ignored and the pin is driven as an extra clock output.

Top module: `clkgrp_stop_ctl`

## Requirements
- R1: While `rst_n` is low every `clk_out` bit is 0. After `rst_n` rises during a low phase, enabled outputs give no pulse at the first rising edge and pulse at every rising edge from the second onward.
- R2: A `clk_out` bit changes state only while `clk_src` is low. No output is high during a low phase of `clk_src`, and every delivered pulse lasts the full high phase.
- R3: With `mobile_mode`=1 and the minimum run already met, take `stop_req_n` low during a low phase. Stoppable outputs then still pulse at the next three rising edges and give no pulse from the fourth onward (default `SYNC_STAGES`=2).
- R4: When `stop_req_n` returns high during a low phase, stopped outputs give no pulse at the next three rising edges and resume at the fourth.
- R5: After a restart the group gives at least `MIN_RUN` pulses (default 10) before it stops again. If the request is already active, it stops right after the `MIN_RUN`-th pulse.
- R6: Outputs whose bit is set in `FREE_MASK` (default bit 0) are never stopped by the request.
- R7: With `exempt_en`=1 the output at index `EXEMPT_IDX` (default 3) keeps running while the group is stopped. With `exempt_en`=0 it stops with the group. A change takes effect from the second rising edge after it.
- R8: With `mobile_mode`=0 the request is ignored, so all enabled outputs run, `aux_pin_oe` is 1 and `aux_pin_out` follows `aux_clk`. With `mobile_mode`=1, `aux_pin_oe` and `aux_pin_out` are 0.
- R9: Clearing bit i of `out_en` holds `clk_out[i]` low from the second rising edge after the change. The other outputs are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Divided source clock of the group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low group stop request |
| mobile_mode | input | 1 | 1 = shared pin is the stop input, 0 = shared pin is a clock output |
| exempt_en | input | 1 | Keep output `EXEMPT_IDX` running during a stop |
| out_en | input | N_OUT | Per-output enable, 0 holds the output low |
| aux_clk | input | 1 | Clock driven onto the shared pin in desktop mode |
| clk_out | output | N_OUT | Gated group clock outputs |
| aux_pin_out | output | 1 | Shared pin data in desktop mode |
| aux_pin_oe | output | 1 | Shared pin output enable |

## Verification
A run/halt controller in the wrong state shows up at the ports within one rising edge. Either a stoppable output pulses while it should be stopped, or it misses a pulse that R4 or R5 requires. The bench counts pulses per output in windows of known length, so an error of one cycle in the synchronizer depth or in the run counter changes a count. A falling-edge enable register that picks up the wrong value either clips a pulse or drives an output high during a low phase. A separate monitor samples every low phase to catch that.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;
  typedef enum logic {
    GRP_RUN  = 1'b0,
    GRP_HALT = 1'b1
  } grp_state_e;
endpackage

// File: rtl/ckstop_sync.sv
module ckstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= async_n;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ckstop_runctl.sv
module ckstop_runctl
  import ckstop_pkg::*;
#(
  parameter int MIN_RUN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync_n,
  input  logic mobile_mode,
  output logic run_now,
  output logic grp_en_q
);
  localparam int CW = $clog2(MIN_RUN + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_RUN);
  localparam logic [CW-1:0] CNT_NEED = CW'(MIN_RUN - 1);

  grp_state_e    state_q;
  logic [CW-1:0] run_cnt_q;
  logic          stop_active;
  logic          min_met;

  assign stop_active = mobile_mode & ~req_sync_n;
  assign min_met     = grp_en_q && (run_cnt_q >= CNT_NEED);
  assign run_now     = (state_q == GRP_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= GRP_RUN;
      run_cnt_q <= '0;
    end else begin
      case (state_q)
        GRP_RUN: begin
          if (grp_en_q && run_cnt_q != CNT_MAX) run_cnt_q <= run_cnt_q + CW'(1);
          if (stop_active && min_met) state_q <= GRP_HALT;
        end
        default: begin
          if (!stop_active) begin
            state_q   <= GRP_RUN;
            run_cnt_q <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) grp_en_q <= 1'b0;
    else        grp_en_q <= run_now;
  end
endmodule

// File: rtl/ckstop_gate.sv
module ckstop_gate #(
  parameter int              N_OUT      = 4,
  parameter logic [N_OUT-1:0] FREE_MASK = 1,
  parameter int              EXEMPT_IDX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_now,
  input  logic             exempt_en,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] clk_out
);
  logic [N_OUT-1:0] oen_q;

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      localparam logic IS_FREE   = FREE_MASK[i];
      localparam logic IS_EXEMPT = (i == EXEMPT_IDX);
      logic keep_running;
      assign keep_running = IS_FREE | (IS_EXEMPT & exempt_en);

      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) oen_q[i] <= 1'b0;
        else        oen_q[i] <= out_en[i] & (run_now | keep_running);
      end

      assign clk_out[i] = clk & oen_q[i];
    end
  endgenerate
endmodule

// File: rtl/clkgrp_stop_ctl.sv
module clkgrp_stop_ctl #(
  parameter int               N_OUT       = 4,
  parameter int               SYNC_STAGES = 2,
  parameter int               MIN_RUN     = 10,
  parameter logic [N_OUT-1:0] FREE_MASK   = 1,
  parameter int               EXEMPT_IDX  = 3
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic             mobile_mode,
  input  logic             exempt_en,
  input  logic [N_OUT-1:0] out_en,
  input  logic             aux_clk,
  output logic [N_OUT-1:0] clk_out,
  output logic             aux_pin_out,
  output logic             aux_pin_oe
);
  logic req_sync_n;
  logic run_now;
  logic grp_en_q;

  ckstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .async_n (stop_req_n),
    .sync_n  (req_sync_n)
  );

  ckstop_runctl #(.MIN_RUN(MIN_RUN)) u_runctl (
    .clk         (clk_src),
    .rst_n       (rst_n),
    .req_sync_n  (req_sync_n),
    .mobile_mode (mobile_mode),
    .run_now     (run_now),
    .grp_en_q    (grp_en_q)
  );

  ckstop_gate #(
    .N_OUT      (N_OUT),
    .FREE_MASK  (FREE_MASK),
    .EXEMPT_IDX (EXEMPT_IDX)
  ) u_gate (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .run_now   (run_now),
    .exempt_en (exempt_en),
    .out_en    (out_en),
    .clk_out   (clk_out)
  );

  assign aux_pin_oe  = ~mobile_mode;
  assign aux_pin_out = aux_clk & ~mobile_mode;
endmodule

// File: rtl/ckstop_chk.sv
module ckstop_chk #(
  parameter int               N_OUT       = 4,
  parameter int               SYNC_STAGES = 2,
  parameter int               MIN_RUN     = 10,
  parameter logic [N_OUT-1:0] FREE_MASK   = 1,
  parameter int               EXEMPT_IDX  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req_n,
  input logic             mobile_mode,
  input logic             exempt_en,
  input logic [N_OUT-1:0] out_en,
  input logic [N_OUT-1:0] clk_out,
  input logic             grp_en
);
  localparam logic [15:0] LOW_LIM  = 16'(SYNC_STAGES + 2 + MIN_RUN);
  localparam logic [15:0] HIGH_LIM = 16'(SYNC_STAGES + 1);
  localparam logic [15:0] RUN_LIM  = 16'(MIN_RUN);
  localparam logic [N_OUT-1:0] EXEMPT_BIT = N_OUT'(1) << EXEMPT_IDX;

  logic [15:0] low_cnt, high_cnt, pulse_cnt, age, neg_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0; high_cnt <= '0; pulse_cnt <= '0; age <= '0;
    end else begin
      if (age != 16'hFFFF) age <= age + 16'd1;
      if (!stop_req_n && mobile_mode) begin
        if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
      end else low_cnt <= '0;
      if (stop_req_n || !mobile_mode) begin
        if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 16'd1;
      end else high_cnt <= '0;
      if (grp_en) begin
        if (pulse_cnt != 16'hFFFF) pulse_cnt <= pulse_cnt + 16'd1;
      end else pulse_cnt <= '0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_age <= '0;
    else if (neg_age != 16'hFFFF) neg_age <= neg_age + 16'd1;
  end

  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt >= LOW_LIM) |-> !grp_en); // R3

  AST_RESTART_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (high_cnt >= HIGH_LIM) |-> grp_en); // R4

  AST_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_en && $past(grp_en)) |-> (pulse_cnt >= RUN_LIM)); // R5

  AST_DESKTOP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mobile_mode && $past(!mobile_mode) && age >= 16'd2) |-> grp_en); // R8

  AST_FREE_RUN: assert property (@(negedge clk) disable iff (!rst_n)
    (neg_age >= 16'd2) |->
      ((clk_out & $past(out_en) & FREE_MASK) == ($past(out_en) & FREE_MASK))); // R6

  AST_EXEMPT_RUN: assert property (@(negedge clk) disable iff (!rst_n)
    (neg_age >= 16'd2 && $past(exempt_en)) |->
      ((clk_out & $past(out_en) & EXEMPT_BIT) == ($past(out_en) & EXEMPT_BIT))); // R7

  AST_DISABLED_LOW: assert property (@(negedge clk) disable iff (!rst_n)
    (clk_out & ~$past(out_en)) == '0); // R9
endmodule

bind clkgrp_stop_ctl ckstop_chk #(
  .N_OUT       (N_OUT),
  .SYNC_STAGES (SYNC_STAGES),
  .MIN_RUN     (MIN_RUN),
  .FREE_MASK   (FREE_MASK),
  .EXEMPT_IDX  (EXEMPT_IDX)
) u_chk (
  .clk         (clk_src),
  .rst_n       (rst_n),
  .stop_req_n  (stop_req_n),
  .mobile_mode (mobile_mode),
  .exempt_en   (exempt_en),
  .out_en      (out_en),
  .clk_out     (clk_out),
  .grp_en      (grp_en_q)
);

// File: tb/clkgrp_stop_ctl_tb.sv
`timescale 1ns/1ps
module clkgrp_stop_ctl_tb;
  localparam int N_OUT   = 4;
  localparam int MIN_RUN = 10;

  logic clk = 1'b0;
  logic aux_clk = 1'b0;
  logic rst_n, stop_req_n, mobile_mode, exempt_en;
  logic [N_OUT-1:0] out_en;
  logic [N_OUT-1:0] clk_out;
  logic aux_pin_out, aux_pin_oe;

  int n_checks = 0;
  int n_fail = 0;
  int pc[N_OUT];
  bit glitch_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always #3 aux_clk = ~aux_clk;

  clkgrp_stop_ctl #(
    .N_OUT(N_OUT), .SYNC_STAGES(2), .MIN_RUN(MIN_RUN),
    .FREE_MASK(4'b0001), .EXEMPT_IDX(3)
  ) u_dut (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .mobile_mode(mobile_mode), .exempt_en(exempt_en), .out_en(out_en),
    .aux_clk(aux_clk), .clk_out(clk_out), .aux_pin_out(aux_pin_out),
    .aux_pin_oe(aux_pin_oe)
  );

  // R2: nothing may be high during a low phase
  always @(negedge clk) begin
    #2;
    if (clk_out != '0) glitch_seen = 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_low();
    @(negedge clk); #1;
  endtask

  task automatic count_pulses(input int n);
    for (int i = 0; i < N_OUT; i++) pc[i] = 0;
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #2;
      for (int i = 0; i < N_OUT; i++) if (clk_out[i]) pc[i]++;
    end
  endtask

  task automatic expect_pc(input string req, input int idx, input int exp);
    check(pc[idx] == exp, req, pc[idx], exp);
  endtask

  task automatic t_reset();
    rst_n = 0; stop_req_n = 1; mobile_mode = 1; exempt_en = 0; out_en = '1;
    count_pulses(5);
    for (int i = 0; i < N_OUT; i++) expect_pc("R1 reset low", i, 0);
    to_low(); rst_n = 1;
    count_pulses(1);
    expect_pc("R1 first edge idle", 1, 0);
    count_pulses(4);
    for (int i = 0; i < N_OUT; i++) expect_pc("R1 running", i, 4);
    count_pulses(20);
  endtask

  task automatic t_stop();
    to_low(); stop_req_n = 0;
    count_pulses(3);
    expect_pc("R3 pulses before stop", 1, 3);
    count_pulses(10);
    expect_pc("R3 stopped out1", 1, 0);
    expect_pc("R3 stopped out2", 2, 0);
    expect_pc("R7 exempt off stops", 3, 0);
    expect_pc("R6 free runs", 0, 10);
  endtask

  task automatic t_restart_minrun();
    to_low(); stop_req_n = 1;
    count_pulses(3);
    expect_pc("R4 no early pulse", 1, 0);
    count_pulses(1);
    expect_pc("R4 resume at 4th edge", 1, 1);
    to_low(); stop_req_n = 0;
    count_pulses(20);
    expect_pc("R5 run length after first", 1, MIN_RUN - 1);
    expect_pc("R6 free runs", 0, 20);
  endtask

  task automatic t_exempt();
    to_low(); exempt_en = 1;
    count_pulses(2);
    count_pulses(5);
    expect_pc("R7 exempt runs", 3, 5);
    expect_pc("R7 others stopped", 1, 0);
    to_low(); exempt_en = 0;
    count_pulses(2);
    count_pulses(5);
    expect_pc("R7 exempt cleared", 3, 0);
  endtask

  task automatic t_disable();
    to_low(); stop_req_n = 1;
    count_pulses(15);
    to_low(); out_en = 4'b1011;
    count_pulses(1);
    expect_pc("R9 not before 2nd edge", 2, 1);
    count_pulses(5);
    expect_pc("R9 disabled low", 2, 0);
    expect_pc("R9 neighbour runs", 1, 5);
    to_low(); out_en = 4'b1010;
    count_pulses(2);
    count_pulses(5);
    expect_pc("R9 free output disabled", 0, 0);
    expect_pc("R9 neighbour runs", 3, 5);
    to_low(); out_en = '1;
    count_pulses(2);
  endtask

  task automatic t_desktop();
    bit aux_bad = 0;
    to_low(); mobile_mode = 0; stop_req_n = 0;
    count_pulses(4);
    count_pulses(20);
    for (int i = 0; i < N_OUT; i++) expect_pc("R8 desktop ignores request", i, 20);
    check(aux_pin_oe == 1'b1, "R8 aux oe desktop", aux_pin_oe, 1);
    for (int k = 0; k < 12; k++) begin
      #1.5;
      if (aux_pin_out !== aux_clk) aux_bad = 1;
    end
    check(!aux_bad, "R8 aux follows aux_clk", aux_bad, 0);
    to_low(); mobile_mode = 1;
    count_pulses(3);
    count_pulses(10);
    expect_pc("R8 mobile request acts", 1, 0);
    check(aux_pin_oe == 1'b0, "R8 aux oe mobile", aux_pin_oe, 0);
    check(aux_pin_out == 1'b0, "R8 aux low mobile", aux_pin_out, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stop();
    t_restart_minrun();
    t_exempt();
    t_disable();
    t_desktop();
    check(!glitch_seen, "R2 no high during low phase", glitch_seen, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule